// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block keeps per-source interrupt state for a processor core and decides which waiting interrupt the core should take next. Each of the sixteen sources has an enable bit, a pending bit, an active bit and a four-bit priority field. A configuration input splits that field into an upper preemption level and a lower sub-level. A numerically smaller field means more urgent. The preemption level alone decides whether a new interrupt may cut into the handler that is running. The full field, then the source index, decides which of several waiting sources goes first.

Software changes the state through a single write port. The port offers write-one-to-set and write-one-to-clear views of the enable and pending bits, a software trigger that pends a source by its number, and a priority write. Hardware request lines also set pending bits. The core sees a request strobe with the winning source number. It answers with an acknowledge, which moves that source from pending to active and pushes its level onto a nesting stack. It later sends an end-of-service, which retires the innermost handler and restores the level of the handler it had interrupted.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset, every enable, pending and active bit is 0, `req_o` is 0, `req_id_o` is 0, and `cur_level_o` holds the idle value 16.
- R2: A write with `wr_sel`=0 sets, and `wr_sel`=1 clears, each enable bit whose `wr_data` bit is 1. Bits written as 0 keep their value.
- R3: `wr_sel`=2 sets and `wr_sel`=3 clears pending bits with the same write-one rule. A high bit of `src_req` sets that source's pending bit. A set wins over a clear in the same cycle.
- R4: A write with `wr_sel`=4 sets the pending bit of the source numbered by `wr_data[3:0]`. A disabled source may be pending, but it is never requested.
- R5: A source can be a candidate only if it is pending, enabled and not active. When `req_o` is 0, `req_id_o` reads 0.
- R6: Among candidates, the smallest 4-bit priority value wins. Among equal values, the lowest source index wins. The priority write is `wr_sel`=5, with the value in `wr_data[3:0]` and the source in `wr_data[7:4]`.
- R7: `req_o` is high only when the winner's preemption level is strictly below `cur_level_o`. A lower sub-level with an equal preemption level never preempts.
- R8: The preemption level is the top `grp_bits` bits of the priority field, with `grp_bits` limited to 4. When `grp_bits`=0, every level is 0, so nothing nests.
- R9: An acknowledge while `req_o` is 1 clears the winner's pending bit, sets its active bit and makes its level the current level. An acknowledge while `req_o` is 0 changes nothing.
- R10: An end-of-service clears the active bit of the most recently acknowledged running source and restores the previous level, or 16 when none remains. With nothing running it changes nothing. When it arrives together with an acknowledge, the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_bits | input | 3 | Number of upper priority bits that form the preemption level |
| src_req | input | 16 | Hardware request per source, sets pending |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target: 0 en set, 1 en clear, 2 pend set, 3 pend clear, 4 trigger, 5 priority |
| wr_data | input | 16 | Write data |
| ack_i | input | 1 | Core accepts the requested source |
| eoi_i | input | 1 | Core finished the innermost handler |
| req_o | output | 1 | Request to the core |
| req_id_o | output | 4 | Number of the requested source |
| cur_level_o | output | 5 | Preemption level of the running handler, 16 when idle |
| enable_o | output | 16 | Enable bits |
| pending_o | output | 16 | Pending bits |
| active_o | output | 16 | Active bits |

## Verification
All state is in registers, and the request and level outputs are combinational from those registers. Every write, acknowledge, end-of-service or hardware request therefore shows up in the outputs exactly one clock edge after the cycle in which it was driven. The bench drives inputs on the falling edge and queues the expected outputs with that stimulus. The monitor pops and compares the queued values 2 ns after the next rising edge, which is the first point at which the updated registers are visible. The `grp_bits` input acts on the request without a register, but the bench still checks it at the same point.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned NSRC_DEF = 16;
  localparam int unsigned PW_DEF   = 4;

  typedef enum logic [2:0] {
    WR_EN_SET  = 3'd0,
    WR_EN_CLR  = 3'd1,
    WR_PD_SET  = 3'd2,
    WR_PD_CLR  = 3'd3,
    WR_SWTRIG  = 3'd4,
    WR_PRIO    = 3'd5
  } wr_sel_e;
endpackage

// File: rtl/irq_src_bits.sv
module irq_src_bits #(
  parameter int unsigned NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] en_set,
  input  logic [NSRC-1:0] en_clr,
  input  logic [NSRC-1:0] pd_set,
  input  logic [NSRC-1:0] pd_clr,
  input  logic [NSRC-1:0] act_set,
  input  logic [NSRC-1:0] act_clr,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pd_q,
  output logic [NSRC-1:0] act_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic en_d, pd_d, act_d;

    always_comb begin
      en_d  = (en_q[i]  & ~en_clr[i])  | en_set[i];
      pd_d  = (pd_q[i]  & ~pd_clr[i])  | pd_set[i];
      act_d = (act_q[i] & ~act_clr[i]) | act_set[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i]  <= 1'b0;
        pd_q[i]  <= 1'b0;
        act_q[i] <= 1'b0;
      end else begin
        en_q[i]  <= en_d;
        pd_q[i]  <= pd_d;
        act_q[i] <= act_d;
      end
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NSRC = 16,
  parameter int unsigned PW   = 4,
  localparam int unsigned IW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]    cand,
  input  logic [NSRC*PW-1:0] prio_flat,
  output logic               valid,
  output logic [IW-1:0]      best_idx,
  output logic [PW-1:0]      best_prio
);
  always_comb begin
    valid     = 1'b0;
    best_idx  = '0;
    best_prio = '1;
    // scan downward so an equal value at a lower index replaces the holder
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i] && (!valid || prio_flat[i*PW +: PW] <= best_prio)) begin
        valid     = 1'b1;
        best_idx  = IW'(i);
        best_prio = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int unsigned NSRC = 16,
  parameter int unsigned PW   = 4,
  localparam int unsigned IW  = $clog2(NSRC),
  localparam int unsigned LW  = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [IW-1:0] push_id,
  input  logic [LW-1:0] push_lvl,
  output logic          empty,
  output logic [IW-1:0] top_id,
  output logic [LW-1:0] top_lvl
);
  localparam logic [LW-1:0] IDLE = {1'b1, {PW{1'b0}}};

  logic [IW:0]   depth_q, depth_d;
  logic [IW-1:0] id_mem  [NSRC];
  logic [LW-1:0] lvl_mem [NSRC];

  assign empty   = (depth_q == '0);
  assign top_id  = empty ? '0 : id_mem[IW'(depth_q - 1'b1)];
  assign top_lvl = empty ? IDLE : lvl_mem[IW'(depth_q - 1'b1)];

  always_comb begin
    depth_d = depth_q;
    if (pop && !empty)                       depth_d = depth_q - 1'b1;
    else if (push && depth_q < (IW+1)'(NSRC)) depth_d = depth_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= '0;
    else        depth_q <= depth_d;
  end

  always_ff @(posedge clk) begin
    if (push && !pop && depth_q < (IW+1)'(NSRC)) begin
      id_mem[IW'(depth_q)]  <= push_id;
      lvl_mem[IW'(depth_q)] <= push_lvl;
    end
  end
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NSRC = NSRC_DEF,
  parameter int unsigned PW   = PW_DEF,
  localparam int unsigned IW  = $clog2(NSRC),
  localparam int unsigned LW  = PW + 1,
  localparam int unsigned GW  = $clog2(PW + 1),
  localparam int unsigned DW  = (NSRC > PW + IW) ? NSRC : PW + IW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [GW-1:0]   grp_bits,
  input  logic [NSRC-1:0] src_req,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic            ack_i,
  input  logic            eoi_i,
  output logic            req_o,
  output logic [IW-1:0]   req_id_o,
  output logic [LW-1:0]   cur_level_o,
  output logic [NSRC-1:0] enable_o,
  output logic [NSRC-1:0] pending_o,
  output logic [NSRC-1:0] active_o
);
  logic [NSRC-1:0] en_set, en_clr, pd_set, pd_clr, act_set, act_clr;
  logic [NSRC-1:0] en_q, pd_q, act_q, cand;
  logic [PW-1:0]   prio_q [NSRC];
  logic [PW-1:0]   prio_d [NSRC];
  logic [NSRC*PW-1:0] prio_flat;
  logic            win_vld, take, pop, stk_empty;
  logic [IW-1:0]   win_idx, top_id;
  logic [PW-1:0]   win_prio;
  logic [LW-1:0]   win_lvl, top_lvl;
  logic [GW-1:0]   gb, shamt;
  wr_sel_e         sel;

  assign sel = wr_sel_e'(wr_sel);

  // write decode and handshake control
  always_comb begin
    en_set = '0; en_clr = '0; pd_set = src_req; pd_clr = '0;
    for (int i = 0; i < NSRC; i++) prio_d[i] = prio_q[i];
    if (wr_en) begin
      case (sel)
        WR_EN_SET: en_set = wr_data[NSRC-1:0];
        WR_EN_CLR: en_clr = wr_data[NSRC-1:0];
        WR_PD_SET: pd_set = src_req | wr_data[NSRC-1:0];
        WR_PD_CLR: pd_clr = wr_data[NSRC-1:0];
        WR_SWTRIG: pd_set = src_req | (NSRC'(1) << wr_data[IW-1:0]);
        WR_PRIO:   prio_d[wr_data[PW +: IW]] = wr_data[PW-1:0];
        default:   ;
      endcase
    end
    take    = ack_i && req_o && !eoi_i;
    pop     = eoi_i && !stk_empty;
    act_set = take ? (NSRC'(1) << win_idx) : '0;
    act_clr = pop  ? (NSRC'(1) << top_id)  : '0;
    if (take) pd_clr = pd_clr | act_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= prio_d[i];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flat
    assign prio_flat[i*PW +: PW] = prio_q[i];
  end

  irq_src_bits #(.NSRC(NSRC)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
    .act_set(act_set), .act_clr(act_clr),
    .en_q(en_q), .pd_q(pd_q), .act_q(act_q)
  );

  assign cand = pd_q & en_q & ~act_q;

  irq_pick #(.NSRC(NSRC), .PW(PW)) u_pick (
    .cand(cand), .prio_flat(prio_flat),
    .valid(win_vld), .best_idx(win_idx), .best_prio(win_prio)
  );

  // preemption level = upper gb bits of the field
  assign gb      = (grp_bits > GW'(PW)) ? GW'(PW) : grp_bits;
  assign shamt   = GW'(PW) - gb;
  assign win_lvl = LW'(win_prio) >> shamt;

  irq_nest_stack #(.NSRC(NSRC), .PW(PW)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(take), .pop(pop), .push_id(win_idx), .push_lvl(win_lvl),
    .empty(stk_empty), .top_id(top_id), .top_lvl(top_lvl)
  );

  assign req_o       = win_vld && (win_lvl < top_lvl);
  assign req_id_o    = req_o ? win_idx : '0;
  assign cur_level_o = top_lvl;
  assign enable_o    = en_q;
  assign pending_o   = pd_q;
  assign active_o    = act_q;
endmodule

// File: rtl/irq_nest_arb_chk.sv
module irq_nest_arb_chk #(
  parameter int unsigned NSRC = 16,
  parameter int unsigned PW   = 4,
  localparam int unsigned IW  = $clog2(NSRC),
  localparam int unsigned LW  = PW + 1,
  localparam int unsigned DW  = (NSRC > PW + IW) ? NSRC : PW + IW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      wr_sel,
  input logic [DW-1:0]   wr_data,
  input logic            ack_i,
  input logic            eoi_i,
  input logic            req_o,
  input logic [IW-1:0]   req_id_o,
  input logic [LW-1:0]   cur_level_o,
  input logic [NSRC-1:0] enable_o,
  input logic [NSRC-1:0] pending_o,
  input logic [NSRC-1:0] active_o
);
  localparam logic [LW-1:0] IDLE = {1'b1, {PW{1'b0}}};

  // R2
  en_set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=>
      ((enable_o & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0])));

  // R5
  req_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (pending_o[req_id_o] && enable_o[req_id_o] && !active_o[req_id_o]));

  // R7
  no_req_at_top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (cur_level_o != '0));

  // R9
  ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_o && !eoi_i) |=> active_o[$past(req_id_o)]);

  // R9
  stray_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !req_o && !eoi_i) |=> $stable(active_o));

  // R10
  idle_eoi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && cur_level_o == IDLE) |=> $stable(active_o));
endmodule

bind irq_nest_arb irq_nest_arb_chk #(.NSRC(NSRC), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ack_i(ack_i), .eoi_i(eoi_i), .req_o(req_o), .req_id_o(req_id_o),
  .cur_level_o(cur_level_o), .enable_o(enable_o), .pending_o(pending_o),
  .active_o(active_o)
);

// File: tb/irq_nest_arb_test.sv
module irq_nest_arb_test;
  logic        clk, rst_n;
  logic [2:0]  grp_bits;
  logic [15:0] src_req;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;
  logic        ack_i, eoi_i;
  logic        req_o;
  logic [3:0]  req_id_o;
  logic [4:0]  cur_level_o;
  logic [15:0] enable_o, pending_o, active_o;

  typedef struct {
    string       tag;
    logic        req;
    logic [3:0]  id;
    logic [4:0]  lvl;
    logic [15:0] en, pd, act;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  bit   done  = 0;

  irq_nest_arb uut (
    .clk(clk), .rst_n(rst_n), .grp_bits(grp_bits), .src_req(src_req),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ack_i(ack_i),
    .eoi_i(eoi_i), .req_o(req_o), .req_id_o(req_id_o),
    .cur_level_o(cur_level_o), .enable_o(enable_o), .pending_o(pending_o),
    .active_o(active_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // drive one cycle of stimulus on the falling edge
  task automatic drive(input logic we, input logic [2:0] sel,
                       input logic [15:0] d, input logic ak, input logic eo,
                       input logic [15:0] sr);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; ack_i = ak; eoi_i = eo; src_req = sr;
  endtask

  task automatic idle();
    drive(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic expect_out(input string tag, input logic r, input logic [3:0] id,
                            input logic [4:0] lv, input logic [15:0] en,
                            input logic [15:0] pd, input logic [15:0] ac);
    exp_t e;
    e.tag = tag; e.req = r; e.id = id; e.lvl = lv; e.en = en; e.pd = pd; e.act = ac;
    q.push_back(e);
  endtask

  // monitor: results of a falling-edge stimulus are due after the next rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (req_o !== e.req || req_id_o !== e.id || cur_level_o !== e.lvl ||
          enable_o !== e.en || pending_o !== e.pd || active_o !== e.act) begin
        bad++;
        $display("FAIL %s: got req=%0b id=%0d lvl=%0d en=%h pd=%h act=%h exp req=%0b id=%0d lvl=%0d en=%h pd=%h act=%h",
                 e.tag, req_o, req_id_o, cur_level_o, enable_o, pending_o, active_o,
                 e.req, e.id, e.lvl, e.en, e.pd, e.act);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000 && !done) begin
        bad++; total++;
        $display("FAIL watchdog: got cycles=%0d exp done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; grp_bits = 3'd2; src_req = '0; wr_en = 1'b0; wr_sel = '0;
    wr_data = '0; ack_i = 1'b0; eoi_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();                                   expect_out("R1 reset", 0, 0, 16, 16'h0, 16'h0, 16'h0);
    drive(1, 3'd0, 16'h00F0, 0, 0, 0);        expect_out("R2 en set", 0, 0, 16, 16'h00F0, 16'h0, 16'h0);
    drive(1, 3'd0, 16'h0003, 0, 0, 0);        expect_out("R2 en set keeps", 0, 0, 16, 16'h00F3, 16'h0, 16'h0);
    drive(1, 3'd1, 16'h0010, 0, 0, 0);        expect_out("R2 en clr", 0, 0, 16, 16'h00E3, 16'h0, 16'h0);
    drive(1, 3'd2, 16'h0100, 0, 0, 0);        expect_out("R3 R5 disabled pending", 0, 0, 16, 16'h00E3, 16'h0100, 16'h0);
    drive(1, 3'd4, 16'h0005, 0, 0, 0);        expect_out("R4 sw trigger", 1, 5, 16, 16'h00E3, 16'h0120, 16'h0);
    drive(1, 3'd5, 16'h0059, 0, 0, 0);
    drive(1, 3'd5, 16'h0069, 0, 0, 0);
    drive(1, 3'd5, 16'h0078, 0, 0, 0);
    drive(1, 3'd5, 16'h001C, 0, 0, 0);
    drive(1, 3'd2, 16'h00C2, 0, 0, 0);        expect_out("R6 lowest prio", 1, 7, 16, 16'h00E3, 16'h01E2, 16'h0);
    drive(0, 3'd0, 16'h0, 1, 0, 0);           expect_out("R9 R7 ack, sub-level no preempt", 0, 0, 2, 16'h00E3, 16'h0162, 16'h0080);
    drive(0, 3'd0, 16'h0, 1, 0, 0);           expect_out("R9 stray ack", 0, 0, 2, 16'h00E3, 16'h0162, 16'h0080);
    drive(1, 3'd5, 16'h0004, 0, 0, 0);
    drive(1, 3'd2, 16'h0001, 0, 0, 0);        expect_out("R7 preempt", 1, 0, 2, 16'h00E3, 16'h0163, 16'h0080);
    drive(0, 3'd0, 16'h0, 1, 0, 0);           expect_out("R9 nested ack", 0, 0, 1, 16'h00E3, 16'h0162, 16'h0081);
    drive(0, 3'd0, 16'h0, 0, 1, 0);           expect_out("R10 restore", 0, 0, 2, 16'h00E3, 16'h0162, 16'h0080);
    drive(0, 3'd0, 16'h0, 0, 1, 0);           expect_out("R10 R6 idle, index tie", 1, 5, 16, 16'h00E3, 16'h0162, 16'h0);
    drive(0, 3'd0, 16'h0, 0, 1, 0);           expect_out("R10 empty eoi", 1, 5, 16, 16'h00E3, 16'h0162, 16'h0);
    grp_bits = 3'd0;
    idle();                                   expect_out("R8 g0 idle", 1, 5, 16, 16'h00E3, 16'h0162, 16'h0);
    drive(0, 3'd0, 16'h0, 1, 0, 0);           expect_out("R8 g0 no nesting", 0, 0, 0, 16'h00E3, 16'h0142, 16'h0020);
    drive(0, 3'd0, 16'h0, 0, 1, 0);
    grp_bits = 3'd4;                          expect_out("R8 g4 pick", 1, 6, 16, 16'h00E3, 16'h0142, 16'h0);
    drive(0, 3'd0, 16'h0, 1, 0, 0);           expect_out("R8 g4 level", 0, 0, 9, 16'h00E3, 16'h0102, 16'h0040);
    drive(1, 3'd5, 16'h0013, 0, 0, 0);        expect_out("R8 R7 g4 preempt", 1, 1, 9, 16'h00E3, 16'h0102, 16'h0040);
    drive(0, 3'd0, 16'h0, 1, 1, 0);           expect_out("R10 eoi beats ack", 1, 1, 16, 16'h00E3, 16'h0102, 16'h0);
    drive(1, 3'd3, 16'h0002, 0, 0, 0);        expect_out("R3 pend clr", 0, 0, 16, 16'h00E3, 16'h0100, 16'h0);
    drive(0, 3'd0, 16'h0, 0, 0, 16'h0001);    expect_out("R3 hw request", 1, 0, 16, 16'h00E3, 16'h0101, 16'h0);
    drive(1, 3'd4, 16'h000F, 0, 0, 0);        expect_out("R4 trigger disabled src", 1, 0, 16, 16'h00E3, 16'h8101, 16'h0);
    idle();
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule